// File: doc/BRIEF.md
# Dual Sample-Hold ADC Sequencer

This block is the digital controller for an eight-input analog-to-digital front end. The front end has two sample-and-hold groups of four inputs each. After a convert-start from the selected trigger source, the sequencer builds a converter clock from the system clock with a programmable divider. It then issues four simultaneous-sample strobes. Each strobe captures one group-A input and one group-B input at the same instant, taking the pairs in index order. The analog pipeline is replaced by a digital result stream. The converter returns one 14-bit word per valid pulse, a fixed number of converter clocks after the matching sample, with the group-A word of a pair first and the group-B word second.

The sequencer routes each arriving word to its own channel register and flags words that sit at either rail as out of range. It raises a one-cycle completion pulse when the last word lands. Triggers that arrive during a run are dropped, and results that arrive while the sequencer is idle are dropped too.

Top module: `adc_seq_top`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done, sample and adc_clk are 0, every result register is 0 and every out-of-range bit is 0.
- R2: A run starts at a clock edge where busy is 0 and start_src bit number src_sel is 1. Triggers on the other bits of start_src have no effect.
- R3: While busy is 1, triggers are ignored. The run in progress keeps its timing, and a change of div_sel during the run has no effect.
- R4: The divide ratio D is div_sel captured at the starting edge and clamped to the range 4 to 30. The converter clock period is D system cycles. Within each period, adc_clk is 1 for the first floor(D/2) cycles and 0 for the rest, and it is 0 whenever busy is 0.
- R5: A converter tick is the last system cycle of each D-cycle period, with the first tick ending D cycles after the start edge. Tick 0 and every second tick after it, four in all, assert sample for that cycle. Pair is 0, 1, 2 and 3 on these four strobes.
- R6: The k-th result accepted in a run (k = 0..7) is written to channel (k mod 2)*4 + k/2. Channels 0 to 3 hold group-A inputs 0 to 3, and channels 4 to 7 hold group-B inputs 0 to 3. Channel c occupies res_flat bits [14c+13:14c].
- R7: Storing a word of all zeros or all ones sets that channel's out-of-range bit (oor bit c). Storing any other word clears that bit. Every out-of-range bit is cleared at the starting edge of a run.
- R8: done is 1 for exactly the one cycle after the edge that stores the eighth result. busy falls at that same edge.
- R9: res_valid while busy is 0 changes no result register and no out-of-range bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_sel | input | 5 | Requested converter clock divide ratio |
| src_sel | input | 2 | Index of the trigger source that may start a run |
| start_src | input | 4 | Trigger inputs, one per source |
| res_valid | input | 1 | Converter result word is valid this cycle |
| res_data | input | 14 | Converter result word |
| adc_clk | output | 1 | Divided converter clock |
| sample | output | 1 | Simultaneous-sample strobe to both sample-and-hold groups |
| pair | output | 2 | Input index selected in both groups for the current strobe |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| res_flat | output | 112 | Eight 14-bit channel result registers |
| oor | output | 8 | Per-channel out-of-range flags |

## Verification
Each response is due a set number of cycles after its cause. busy rises at the triggering edge. Sample strobe p falls in system cycle (2p+1)*D-1 counted from that edge. The bench's converter returns word k in the last cycle of converter period k+3, and that word is visible in its register one edge later. done shows in the cycle after the edge that stores the eighth word. A behavioural model in the bench counts cycles from the start edge and derives every output from that count alone. All outputs are compared against the model at each falling edge, so an event that arrives one cycle early or late is reported at the exact cycle it goes wrong.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int NCH  = 8;
    localparam int GRP  = 4;
    localparam int DW   = 14;
    localparam int CH_W = $clog2(NCH);
    localparam int PR_W = $clog2(GRP);

    typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;

    typedef struct packed {
        seq_state_e      st;
        logic            phase;
        logic [PR_W:0]   pairs;
        logic [CH_W-1:0] wr_cnt;
        logic            done;
    } seq_t;
endpackage

// File: rtl/adc_clkdiv.sv
module adc_clkdiv #(
    parameter int DIV_W   = 5,
    parameter int DIV_MIN = 4,
    parameter int DIV_MAX = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick,
    output logic             adc_clk
);
    localparam logic [DIV_W-1:0] LO  = DIV_W'(DIV_MIN);
    localparam logic [DIV_W-1:0] HI  = DIV_W'(DIV_MAX);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] div_d, div_q, cnt_d, cnt_q, clamped;

    always_comb begin
        if (div_in < LO)      clamped = LO;
        else if (div_in > HI) clamped = HI;
        else                  clamped = div_in;
    end

    always_comb begin
        div_d   = div_q;
        cnt_d   = cnt_q;
        tick    = run && (cnt_q == div_q - ONE);
        adc_clk = run && (cnt_q < (div_q >> 1));
        if (restart) begin
            div_d = clamped;
            cnt_d = '0;
        end else if (run) begin
            cnt_d = tick ? '0 : cnt_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= LO;
            cnt_q <= '0;
        end else begin
            div_q <= div_d;
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                wr_en,
    input  logic [CH_W-1:0]     wr_ch,
    input  logic [DW-1:0]       wr_data,
    output logic [NCH*DW-1:0]   res_flat,
    output logic [NCH-1:0]      oor
);
    logic [NCH-1:0][DW-1:0] reg_d, reg_q;
    logic [NCH-1:0]         oor_d, oor_q;

    always_comb begin
        reg_d = reg_q;
        oor_d = oor_q;
        if (clear) oor_d = '0;
        if (wr_en) begin
            reg_d[wr_ch] = wr_data;
            oor_d[wr_ch] = (wr_data == '0) || (&wr_data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
            oor_q <= '0;
        end else begin
            reg_q <= reg_d;
            oor_q <= oor_d;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign res_flat[c*DW +: DW] = reg_q[c];
    end
    assign oor = oor_q;
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int DIV_W   = 5,
    parameter int DIV_MIN = 4,
    parameter int DIV_MAX = 30,
    parameter int NUM_SRC = 4,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIV_W-1:0]   div_sel,
    input  logic [SRC_W-1:0]   src_sel,
    input  logic [NUM_SRC-1:0] start_src,
    input  logic               res_valid,
    input  logic [DW-1:0]      res_data,
    output logic               adc_clk,
    output logic               sample,
    output logic [PR_W-1:0]    pair,
    output logic               busy,
    output logic               done,
    output logic [NCH*DW-1:0]  res_flat,
    output logic [NCH-1:0]     oor
);
    localparam logic [CH_W-1:0] LAST_WR = CH_W'(NCH - 1);

    seq_t            d, q;
    logic            start_go, tick, wr_en;
    logic [CH_W-1:0] wr_ch;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        start_go = (q.st == ST_IDLE) && start_src[src_sel];
        sample   = (q.st == ST_RUN) && tick && !q.phase && !q.pairs[PR_W];
        wr_en    = (q.st == ST_RUN) && res_valid;
        // order A0,B0,A1,B1,...: low bit picks the group, upper bits the input
        wr_ch    = {q.wr_cnt[0], q.wr_cnt[CH_W-1:1]};
        if (start_go) begin
            d.st     = ST_RUN;
            d.phase  = 1'b0;
            d.pairs  = '0;
            d.wr_cnt = '0;
        end else if (q.st == ST_RUN) begin
            if (tick)   d.phase = ~q.phase;
            if (sample) d.pairs = q.pairs + 1'b1;
            if (wr_en) begin
                d.wr_cnt = q.wr_cnt + 1'b1;
                if (q.wr_cnt == LAST_WR) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, phase: 1'b0, pairs: '0, wr_cnt: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy = (q.st == ST_RUN);
    assign done = q.done;
    assign pair = q.pairs[PR_W-1:0];

    adc_clkdiv #(
        .DIV_W  (DIV_W),
        .DIV_MIN(DIV_MIN),
        .DIV_MAX(DIV_MAX)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(start_go),
        .run    (busy),
        .div_in (div_sel),
        .tick   (tick),
        .adc_clk(adc_clk)
    );

    adc_result_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start_go),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .wr_data (res_data),
        .res_flat(res_flat),
        .oor     (oor)
    );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int RW = 112,
    parameter int NC = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          sample,
    input logic          adc_clk,
    input logic [NC-1:0] oor,
    input logic [RW-1:0] res_flat
);
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    a_r5_sample_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> busy);
    a_r4_clk_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !adc_clk);
    a_r7_oor_cleared_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (oor == '0));
    a_r9_idle_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(res_flat));
endmodule

bind adc_seq_top adc_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .sample  (sample),
    .adc_clk (adc_clk),
    .oor     (oor),
    .res_flat(res_flat)
);

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;
    localparam int CVT_LAT = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [4:0]   div_sel = 5'd4;
    logic [1:0]   src_sel = 2'd0;
    logic [3:0]   start_src = 4'b0;
    logic         res_valid = 1'b0;
    logic [13:0]  res_data = 14'd0;
    logic         adc_clk, sample, busy, done;
    logic [1:0]   pair;
    logic [111:0] res_flat;
    logic [7:0]   oor;

    always #4 clk = ~clk;

    adc_seq_top u_dut (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .src_sel(src_sel),
        .start_src(start_src), .res_valid(res_valid), .res_data(res_data),
        .adc_clk(adc_clk), .sample(sample), .pair(pair), .busy(busy),
        .done(done), .res_flat(res_flat), .oor(oor)
    );

    // behavioural reference model
    bit          m_busy = 0, m_done = 0;
    int          m_n = 0, m_D = 4, m_wr = 0;
    logic [13:0] m_reg [8];
    logic [7:0]  m_oor = '0;
    logic [13:0] pat [8];
    int          vectors = 0, miscompares = 0;
    bit          finished = 0;
    string       ph = "R1";

    initial for (int c = 0; c < 8; c++) m_reg[c] = '0;

    function automatic int clampd(int v);
        return (v < 4) ? 4 : (v > 30) ? 30 : v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_n = 0; m_wr = 0; m_oor = '0;
            for (int c = 0; c < 8; c++) m_reg[c] = '0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (res_valid) begin
                    int ch;
                    ch = (m_wr % 2) * 4 + m_wr / 2;
                    m_reg[ch] = res_data;
                    m_oor[ch] = (res_data == 14'h0) || (res_data == 14'h3fff);
                    m_wr++;
                    if (m_wr == 8) begin m_busy = 0; m_done = 1; end
                end
                m_n++;
            end else if (start_src[src_sel]) begin
                m_busy = 1; m_n = 0; m_wr = 0; m_oor = '0;
                m_D = clampd(int'(div_sel));
            end
        end
    end

    task automatic chk1(string req, string what, int act, int exp);
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s (%s phase) %s: actual %0h expected %0h at %0t",
                     req, ph, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit e_clk, e_smp;
        int j;
        vectors++;
        e_clk = m_busy && ((m_n % m_D) < (m_D / 2));
        j     = (m_n + 1) / m_D - 1;
        e_smp = m_busy && ((m_n + 1) % m_D == 0) && (j % 2 == 0) && (j < 8);
        chk1("R8", "busy", int'(busy), int'(m_busy));
        chk1("R8", "done", int'(done), int'(m_done));
        chk1("R4", "adc_clk", int'(adc_clk), int'(e_clk));
        chk1("R5", "sample", int'(sample), int'(e_smp));
        if (e_smp) chk1("R5", "pair", int'(pair), j / 2);
        for (int c = 0; c < 8; c++)
            chk1("R6", $sformatf("result ch%0d", c), int'(res_flat[c*14 +: 14]), int'(m_reg[c]));
        chk1("R7", "oor", int'(oor), int'(m_oor));
    endtask

    // compare at the falling edge, then drive the converter response
    task automatic step();
        @(negedge clk);
        compare();
        res_valid = 1'b0;
        if (m_busy && ((m_n + 1) % m_D == 0)) begin
            int j;
            j = (m_n + 1) / m_D - 1;
            if (j >= CVT_LAT && j - CVT_LAT < 8) begin
                res_valid = 1'b1;
                res_data  = pat[j - CVT_LAT];
            end
        end
    endtask

    task automatic trigger(int src, int dv);
        src_sel = 2'(src);
        div_sel = 5'(dv);
        start_src[src] = 1'b1;
        step();
        start_src = '0;
    endtask

    task automatic finish_run();
        int guard = 0;
        while (m_busy && guard < 2000) begin step(); guard++; end
        if (guard >= 2000) begin
            miscompares++;
            $display("FAIL R8 run did not complete: actual busy expected idle");
        end
        repeat (3) step();
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual still running, expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) pat[k] = 14'h0100 + 14'(k * 14'h0231);
        // R1: reset values
        ph = "R1";
        repeat (3) step();
        rst_n = 1'b1;
        repeat (2) step();

        // R2: only the selected source starts a run
        ph = "R2";
        src_sel = 2'd1;
        start_src = 4'b1101;
        repeat (3) step();
        start_src = '0;
        step();
        trigger(1, 4);
        finish_run();

        // R4/R7: clamp low, rail values
        ph = "R7";
        pat[0] = 14'h0000; pat[3] = 14'h3fff; pat[6] = 14'h3ffe;
        trigger(2, 1);
        finish_run();

        // R4: clamp high, then an odd ratio; rails elsewhere clear old flags
        ph = "R4";
        pat[0] = 14'h0001; pat[3] = 14'h1234; pat[5] = 14'h3fff; pat[7] = 14'h0000;
        trigger(3, 31);
        finish_run();
        trigger(0, 7);
        finish_run();

        // R3: triggers and divider changes during a run are ignored
        ph = "R3";
        for (int k = 0; k < 8; k++) pat[k] = 14'h2000 - 14'(k * 14'h0111);
        trigger(0, 5);
        repeat (20) step();
        start_src = 4'b1111;
        div_sel = 5'd12;
        repeat (6) step();
        start_src = '0;
        finish_run();

        // R9: results while idle are dropped
        ph = "R9";
        for (int i = 0; i < 4; i++) begin
            step();
            res_valid = 1'b1;
            res_data  = (i % 2 == 0) ? 14'h0000 : 14'h0abc;
        end
        step();
        res_valid = 1'b0;
        repeat (3) step();

        finished = 1;
        summary();
        $finish;
    end
endmodule